// File: doc/BRIEF.md
# Dual-Protocol Host Register Interface

This block is the host-facing register front end of a programmable FIR filter. A host reaches it through an asynchronous 8-bit port made of a chip select, two active-low strobes and a 2-bit address. Before the port is locked it accepts only writes to the configuration register. The value written there picks one of two bus protocols and then locks that choice. With protocol 1 the first strobe writes and the second strobe reads. With protocol 0 the first strobe is a data strobe and the second pin is a read/write level.

All host pins, including address and data, pass through a two-stage synchroniser into the core clock. A falling edge of the first strobe is detected there, so each strobe gives exactly one register write. Reads are combinational from the pins. The data bus is enabled only while a locked, selected read is in progress.

Behind the port there are four registers: configuration, normalisation/rounding, filter order, and a write-only coefficient port. The coefficient port packs byte pairs into 16-bit coefficients and sends each one to the filter engine as a single-cycle command. The command carries a running index and a flag that marks the final tap.

Two state machines control the block. The lock machine has states `LK_OPEN` and `LK_HELD`. It moves from `LK_OPEN` to `LK_HELD` on an accepted configuration write with bit 3 set, and back on an accepted configuration write with bit 3 clear. The byte-pair machine has states `CB_FIRST` and `CB_SECOND`. A coefficient byte moves it from `CB_FIRST` to `CB_SECOND`. The second byte returns it to `CB_FIRST` and issues the coefficient. A filter-order write forces it back to `CB_FIRST`.

Top module: `hostport_regs`

## Requirements
- R1: After reset the configuration writable bits [4:0] read 5'b00010: protocol select (bit 1) is 1 and start, byte order, lock and mode are 0. The normalisation register is 0, the order register is 0 and the port is unlocked.
- R2: While unlocked, a falling edge of the first strobe with chip select low is a write only when the address is 1 (configuration), whatever the second strobe is. Writes to any other address are dropped, coefficient commands are not issued, and reads are not served.
- R3: With configuration bit 1 = 1, the first strobe low writes and the second strobe low reads.
- R4: With configuration bit 1 = 0, the first strobe is a data strobe and the second pin gives direction: 1 = read, 0 = write. A data strobe with the direction pin at 1 changes no register.
- R5: While locked, writes to configuration leave bit 1 unchanged and update bits 0, 2, 3 and 4. Writing bit 3 = 0 unlocks the port.
- R6: Register map: address 1 reads {last-coefficient, last-sub-filter, buffer-full status inputs in bits 7:5, writable bits 4:0}. Address 2 holds 5 bits (bit 4 = rounding enable, bits 3:0 = window select) and reads 0 in bits 7:5. Address 3 holds the 8-bit order (taps minus one). Address 0 reads 0x00.
- R7: Two byte writes to address 0 form one coefficient. Configuration bit 2 = 1 means the MSB byte comes first, 0 means the LSB byte comes first. Each pair gives exactly one single-cycle coefficient strobe, and the indices run 0, 1, 2 and so on.
- R8: A write to the order register resets the coefficient index to 0 and discards any half-assembled pair.
- R9: The last-coefficient flag is high with the coefficient strobe exactly when the index equals the order register.
- R10: Holding a strobe low for any length of time gives exactly one access.
- R11: The data bus enable and data output are 1 and the selected register only during a locked, chip-selected read. Otherwise they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low master reset; also clears the lock |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_strb_a_n | input | 1 | Data strobe (protocol 0) or write strobe (protocol 1), active low |
| hb_strb_b_n | input | 1 | Read/write level (protocol 0) or read strobe (protocol 1) |
| hb_addr | input | 2 | Host register address |
| hb_data_in | input | 8 | Host write data |
| hb_data_out | output | 8 | Host read data |
| hb_data_oe | output | 1 | Drive enable for the host data bus |
| st_buf_full | input | 1 | Engine status: input buffer full |
| st_last_sub | input | 1 | Engine status: last sub-filter in use |
| st_last_coef | input | 1 | Engine status: last coefficient in use |
| cfg_run | output | 1 | Filtering enabled |
| cfg_proto | output | 1 | Bus protocol select |
| cfg_msb_first | output | 1 | Coefficient byte order, 1 = MSB first |
| cfg_locked | output | 1 | Configuration locked |
| cfg_seq | output | 1 | Sequential (1) or single (0) mode |
| norm_sel | output | 4 | Output window select |
| norm_round | output | 1 | Rounding enable |
| order_m1 | output | 8 | Tap count minus one |
| coef_we | output | 1 | Coefficient write strobe, one cycle |
| coef_idx | output | 8 | Coefficient index |
| coef_data | output | 16 | Assembled coefficient |
| coef_last | output | 1 | Index equals the order register |

## Verification
An order-register write can arrive while the byte-pair machine holds half a coefficient. The reset of the index and the completion of the pair then compete. The bench provokes this by writing a single coefficient byte, then the order register, then a full pair. It passes only if exactly one coefficient appears, at index 0, made from the two new bytes. The coefficient strobe and the last-tap flag can also rise in the same cycle. This is judged by comparing the flag at every strobe against the index the bench expects.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
    localparam int ADDR_COEF  = 0;
    localparam int ADDR_CFG   = 1;
    localparam int ADDR_NORM  = 2;
    localparam int ADDR_ORDER = 3;

    localparam int CB_RUN   = 0;
    localparam int CB_PROTO = 1;
    localparam int CB_MSB   = 2;
    localparam int CB_LOCK  = 3;
    localparam int CB_SEQ   = 4;

    localparam int NORM_W = 5;

    typedef enum logic [0:0] {LK_OPEN, LK_HELD} lock_st_t;
    typedef enum logic [0:0] {CB_FIRST, CB_SECOND} pair_st_t;
endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '1;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign cur  = stg[STAGES-1];
    assign prev = stg[STAGES];
endmodule

// File: rtl/hostport_decode.sv
module hostport_decode
    import hostport_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          a_n,
    input  logic          a_n_prev,
    input  logic          b_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          proto,
    output logic          wr_go,
    output logic          locked
);
    lock_st_t st, st_nx;

    logic a_fall, sel_ok, cfg_hit;
    assign a_fall  = a_n_prev & ~a_n;
    assign sel_ok  = a_fall & ~cs_n;
    assign cfg_hit = (addr == AW'(ADDR_CFG));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LK_OPEN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        wr_go = 1'b0;
        unique case (st)
            LK_OPEN: begin
                wr_go = sel_ok & cfg_hit;
                if (wr_go && data[CB_LOCK]) st_nx = LK_HELD;
            end
            LK_HELD: begin
                wr_go = sel_ok & (proto ? b_n : ~b_n);
                if (wr_go && cfg_hit && !data[CB_LOCK]) st_nx = LK_OPEN;
            end
        endcase
    end

    assign locked = (st == LK_HELD);
endmodule

// File: rtl/hostport_coef.sv
module hostport_coef
    import hostport_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [DW-1:0]    byte_in,
    input  logic             msb_first,
    input  logic             restart,
    input  logic [IDX_W-1:0] order,
    output logic             coef_we,
    output logic [IDX_W-1:0] coef_idx,
    output logic [2*DW-1:0]  coef_data,
    output logic             coef_last
);
    pair_st_t        st, st_nx;
    logic [DW-1:0]    held;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CB_FIRST;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            CB_FIRST:  if (byte_we) st_nx = CB_SECOND;
            CB_SECOND: if (byte_we) st_nx = CB_FIRST;
        endcase
        if (restart) st_nx = CB_FIRST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            cnt       <= '0;
            coef_we   <= 1'b0;
            coef_idx  <= '0;
            coef_data <= '0;
            coef_last <= 1'b0;
        end else begin
            coef_we <= 1'b0;
            if (restart) begin
                cnt <= '0;
            end else if (byte_we) begin
                unique case (st)
                    CB_FIRST: held <= byte_in;
                    CB_SECOND: begin
                        coef_data <= msb_first ? {held, byte_in} : {byte_in, held};
                        coef_idx  <= cnt;
                        coef_last <= (cnt == order);
                        coef_we   <= 1'b1;
                        cnt       <= cnt + 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hostport_regs.sv
module hostport_regs
    import hostport_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hb_cs_n,
    input  logic          hb_strb_a_n,
    input  logic          hb_strb_b_n,
    input  logic [AW-1:0] hb_addr,
    input  logic [DW-1:0] hb_data_in,
    output logic [DW-1:0] hb_data_out,
    output logic          hb_data_oe,
    input  logic          st_buf_full,
    input  logic          st_last_sub,
    input  logic          st_last_coef,
    output logic          cfg_run,
    output logic          cfg_proto,
    output logic          cfg_msb_first,
    output logic          cfg_locked,
    output logic          cfg_seq,
    output logic [3:0]    norm_sel,
    output logic          norm_round,
    output logic [DW-1:0] order_m1,
    output logic          coef_we,
    output logic [DW-1:0] coef_idx,
    output logic [2*DW-1:0] coef_data,
    output logic          coef_last
);
    localparam int BUS_W = DW + AW + 3;
    localparam int IDX_W = DW;

    logic [BUS_W-1:0] bus_raw, bus_cur, bus_prev;
    assign bus_raw = {hb_data_in, hb_addr, hb_strb_b_n, hb_strb_a_n, hb_cs_n};

    hostport_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (bus_raw),
        .cur  (bus_cur),
        .prev (bus_prev)
    );

    logic          s_cs_n, s_a_n, s_b_n, p_a_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    assign s_cs_n = bus_cur[0];
    assign s_a_n  = bus_cur[1];
    assign s_b_n  = bus_cur[2];
    assign s_addr = bus_cur[3 +: AW];
    assign s_data = bus_cur[3+AW +: DW];
    assign p_a_n  = bus_prev[1];

    logic wr_go, locked;

    hostport_decode #(.AW(AW), .DW(DW)) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (s_cs_n),
        .a_n     (s_a_n),
        .a_n_prev(p_a_n),
        .b_n     (s_b_n),
        .addr    (s_addr),
        .data    (s_data),
        .proto   (cfg_proto),
        .wr_go   (wr_go),
        .locked  (locked)
    );
    assign cfg_locked = locked;

    logic [NORM_W-1:0] norm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_run       <= 1'b0;
            cfg_proto     <= 1'b1;
            cfg_msb_first <= 1'b0;
            cfg_seq       <= 1'b0;
            norm_q        <= '0;
            order_m1      <= '0;
        end else if (wr_go) begin
            unique case (s_addr)
                AW'(ADDR_CFG): begin
                    cfg_run       <= s_data[CB_RUN];
                    cfg_msb_first <= s_data[CB_MSB];
                    cfg_seq       <= s_data[CB_SEQ];
                    if (!locked) cfg_proto <= s_data[CB_PROTO];
                end
                AW'(ADDR_NORM):  norm_q   <= s_data[NORM_W-1:0];
                AW'(ADDR_ORDER): order_m1 <= s_data;
                default: ;
            endcase
        end
    end

    assign norm_sel   = norm_q[3:0];
    assign norm_round = norm_q[4];

    logic byte_we, restart;
    assign byte_we = wr_go & (s_addr == AW'(ADDR_COEF));
    assign restart = wr_go & (s_addr == AW'(ADDR_ORDER));

    hostport_coef #(.DW(DW), .IDX_W(IDX_W)) coef_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (byte_we),
        .byte_in  (s_data),
        .msb_first(cfg_msb_first),
        .restart  (restart),
        .order    (order_m1),
        .coef_we  (coef_we),
        .coef_idx (coef_idx),
        .coef_data(coef_data),
        .coef_last(coef_last)
    );

    logic          rd_sel;
    logic [DW-1:0] rd_mux;

    assign rd_sel = locked & ~hb_cs_n &
                    (cfg_proto ? ~hb_strb_b_n : (~hb_strb_a_n & hb_strb_b_n));

    always_comb begin
        rd_mux = '0;
        unique case (hb_addr)
            AW'(ADDR_CFG):   rd_mux = DW'({st_last_coef, st_last_sub, st_buf_full,
                                           cfg_seq, locked, cfg_msb_first, cfg_proto, cfg_run});
            AW'(ADDR_NORM):  rd_mux = DW'(norm_q);
            AW'(ADDR_ORDER): rd_mux = order_m1;
            default:         rd_mux = '0;
        endcase
    end

    assign hb_data_oe  = rd_sel;
    assign hb_data_out = rd_sel ? rd_mux : '0;
endmodule

// File: rtl/hostport_regs_chk.sv
module hostport_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic hb_cs_n,
    input logic hb_data_oe,
    input logic cfg_locked,
    input logic cfg_proto,
    input logic coef_we
);
    // R11
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_data_oe |-> (cfg_locked && !hb_cs_n));

    // R7
    coef_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |=> !coef_we);

    // R5
    proto_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locked && $past(cfg_locked)) |-> $stable(cfg_proto));

    // R2
    coef_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> cfg_locked);
endmodule

bind hostport_regs hostport_regs_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hb_cs_n   (hb_cs_n),
    .hb_data_oe(hb_data_oe),
    .cfg_locked(cfg_locked),
    .cfg_proto (cfg_proto),
    .coef_we   (coef_we)
);

// File: tb/hostport_regs_tb_top.sv
module hostport_regs_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sa_n = 1'b1, sb_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic oe;
    logic stf = 1'b0, sts = 1'b0, stc = 1'b0;
    logic run, proto, msb, locked, seq, nround, cwe, clast;
    logic [3:0] nsel;
    logic [7:0] order, cidx;
    logic [15:0] cdata;

    int errors = 0, checks = 0;
    int cw_n = 0;
    logic [15:0] cw_data = '0;
    logic [7:0]  cw_idx = '0;
    logic        cw_last = 1'b0;

    always #2 clk = ~clk;

    hostport_regs dut_i (
        .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_strb_a_n(sa_n), .hb_strb_b_n(sb_n),
        .hb_addr(addr), .hb_data_in(din), .hb_data_out(dout), .hb_data_oe(oe),
        .st_buf_full(stf), .st_last_sub(sts), .st_last_coef(stc),
        .cfg_run(run), .cfg_proto(proto), .cfg_msb_first(msb), .cfg_locked(locked),
        .cfg_seq(seq), .norm_sel(nsel), .norm_round(nround), .order_m1(order),
        .coef_we(cwe), .coef_idx(cidx), .coef_data(cdata), .coef_last(clast)
    );

    always @(posedge clk) if (cwe) begin
        cw_n    = cw_n + 1;
        cw_data = cdata;
        cw_idx  = cidx;
        cw_last = clast;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d, bit p0, int hold);
        cs_n = 1'b0; addr = a; din = d; sb_n = p0 ? 1'b0 : 1'b1;
        tick(1); sa_n = 1'b0;
        tick(hold); sa_n = 1'b1;
        tick(3); cs_n = 1'b1; sb_n = 1'b1;
        tick(3);
    endtask

    task automatic bus_rd(logic [1:0] a, bit p0, output logic [7:0] v, output logic e);
        cs_n = 1'b0; addr = a;
        if (p0) begin sb_n = 1'b1; tick(1); sa_n = 1'b0; end
        else    begin sb_n = 1'b0; end
        tick(2); v = dout; e = oe;
        sa_n = 1'b1; sb_n = 1'b1; tick(1); cs_n = 1'b1;
        tick(4);
    endtask

    localparam int NV = 13;
    // {write, addr, data, expected read}
    localparam logic [18:0] TBL [NV] = '{
        {1'b1, 2'd2, 8'h1F, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h1F},
        {1'b1, 2'd2, 8'h3A, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h1A},
        {1'b1, 2'd3, 8'h81, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h81},
        {1'b1, 2'd3, 8'h00, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'h00},
        {1'b1, 2'd1, 8'h1B, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h1B},
        {1'b1, 2'd1, 8'h19, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h1B}
    };

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic e;
        int base;
        tick(3); rst_n = 1'b1; tick(2);
        // R1 reset state
        chk({27'd0, run, proto, msb, locked, seq}, 32'b01000, "R1 cfg bits");
        chk({nround, nsel}, 0, "R1 norm");
        chk(order, 0, "R1 order");
        chk(oe, 0, "R11 idle bus");
        // R2 unlocked: non-config write dropped, read not served
        bus_wr(2'd2, 8'h1F, 1'b0, 4);
        chk({nround, nsel}, 0, "R2 unlocked norm write ignored");
        bus_rd(2'd2, 1'b0, v, e);
        chk(e, 0, "R2 unlocked read not driven");
        // lock with protocol 1
        bus_wr(2'd1, 8'h0A, 1'b0, 4);
        chk({locked, proto, msb}, 3'b110, "R3 locked protocol 1");
        // R3 R5 R6 table walk
        for (int i = 0; i < NV; i++) begin
            if (TBL[i][18]) bus_wr(TBL[i][17:16], TBL[i][15:8], 1'b0, 4);
            else begin
                bus_rd(TBL[i][17:16], 1'b0, v, e);
                chk({e, v}, {1'b1, TBL[i][7:0]}, $sformatf("R6 R5 table row %0d", i));
            end
        end
        chk({run, seq, proto}, 3'b111, "R5 fields after locked write");
        // R6 status bits
        stf = 1'b1; sts = 1'b0; stc = 1'b1;
        bus_rd(2'd1, 1'b0, v, e);
        chk(v, 8'hBB, "R6 status readback");
        stf = 1'b0; stc = 1'b0;
        // R7 R9 coefficients, LSB first
        bus_wr(2'd3, 8'h01, 1'b0, 4);
        bus_wr(2'd0, 8'h34, 1'b0, 4);
        chk(cw_n, 0, "R7 no coef after one byte");
        bus_wr(2'd0, 8'h12, 1'b0, 4);
        chk({cw_n[7:0], cw_data, cw_idx, 7'd0, cw_last}, {8'd1, 16'h1234, 8'd0, 8'd0}, "R7 first coef");
        bus_wr(2'd0, 8'h78, 1'b0, 4);
        bus_wr(2'd0, 8'h56, 1'b0, 4);
        chk({cw_n[7:0], cw_data, cw_idx, 7'd0, cw_last}, {8'd2, 16'h5678, 8'd1, 8'd1}, "R9 last coef");
        // R8 order write discards half pair
        bus_wr(2'd0, 8'hAA, 1'b0, 4);
        bus_wr(2'd3, 8'h03, 1'b0, 4);
        bus_wr(2'd0, 8'hCD, 1'b0, 4);
        bus_wr(2'd0, 8'hAB, 1'b0, 4);
        chk({cw_n[7:0], cw_data, cw_idx, 7'd0, cw_last}, {8'd3, 16'hABCD, 8'd0, 8'd0}, "R8 restart");
        // R10 long strobe
        base = cw_n;
        bus_wr(2'd0, 8'h11, 1'b0, 20);
        chk(cw_n - base, 0, "R10 long strobe single byte");
        bus_wr(2'd0, 8'h22, 1'b0, 4);
        chk({cw_n - base, 8'd0, cw_data, cw_idx}, {32'd1, 8'd0, 16'h2211, 8'd1}, "R10 one access");
        // R5 unlock, relock with protocol 0 and MSB first
        bus_wr(2'd1, 8'h00, 1'b0, 4);
        chk(locked, 0, "R5 unlock");
        bus_wr(2'd1, 8'h0C, 1'b0, 4);
        chk({locked, proto, msb}, 3'b101, "R4 relock protocol 0");
        // R4 protocol 0 writes and reads
        bus_wr(2'd3, 8'h00, 1'b1, 4);
        base = cw_n;
        bus_wr(2'd0, 8'h9A, 1'b1, 4);
        bus_wr(2'd0, 8'hBC, 1'b1, 4);
        chk({cw_n - base, 8'd0, cw_data, cw_idx, 7'd0, cw_last},
            {32'd1, 8'd0, 16'h9ABC, 8'd0, 8'd1}, "R4 R7 MSB first coef");
        bus_wr(2'd2, 8'h15, 1'b1, 4);
        din = 8'h03;
        bus_rd(2'd2, 1'b1, v, e);
        chk({e, v}, {1'b1, 8'h15}, "R4 read in protocol 0");
        chk({nround, nsel}, 5'h15, "R4 read strobe did not write");
        // R11 second pin low alone is no read in protocol 0
        cs_n = 1'b0; addr = 2'd2; sb_n = 1'b0; tick(2);
        chk({oe, dout}, 0, "R11 released outside read");
        sb_n = 1'b1; cs_n = 1'b1; tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule